// File: doc/BRIEF.md
# DRAM Bank State Timing Tracker

This block watches the command stream going to a DRAM device with 32 banks, laid out as 8 bank groups of 4 banks each. For every bank it records whether a row is open, which row that is, and how many clock cycles have passed since the last activate, precharge or refresh that touched the bank. Each presented command gets a verdict in the same cycle: a legal flag and a reason code. The verdict compares the command with the bank's open/closed state and with three programmable minimum intervals in cycles: activate to column access, activate to precharge, and precharge to activate.

A same-bank refresh uses one bank index and hits that index in all eight groups at once. It is accepted only when all eight of those banks are closed and recovered. After it, those banks reject activates until a programmable refresh-busy interval has run out. Banks with other indices are not affected. A half-rate command mode accepts commands only on every second cycle. Long bursts are accepted only on a device configured as x4.

The block that issues commands uses the flag to hold back or flag a command. Only a legal command changes the tracked state. Typical interval settings are 18, 39, 18 and 30 cycles.

Top module: `bank_timing_tracker`

## Requirements
- R1: While cmd_valid is low, cmd_legal and cmd_reason are 0. After reset every bank is closed, and every bank can be activated at once without waiting for a recovery interval.
- R2: The cmd_code values are 0 activate, 1 read, 2 write, 3 precharge and 4 same-bank refresh. Codes 5 to 7 are rejected with reason 7. The bank number is cmd_bg*4+cmd_bank. Bank n maps to bit n of bank_open and to bits n*ROW_W and up of open_row.
- R3: A read or write to a closed bank is rejected with reason 1.
- R4: If an activate is accepted in cycle t, a read or write to that bank in cycle t+k is legal only when k >= cfg_trcd. Otherwise it is rejected with reason 2.
- R5: A precharge to a closed bank is rejected with reason 1. A precharge to an open bank in cycle t+k, where the activate was accepted in cycle t, needs k >= cfg_tras and is otherwise rejected with reason 3. An accepted precharge closes the bank.
- R6: An activate to an open bank is rejected with reason 5. An activate in cycle t+k, where the precharge was accepted in cycle t, needs k >= cfg_trp and is otherwise rejected with reason 4. An accepted activate opens the bank and records cmd_row.
- R7: A refresh with bank index b is rejected with reason 5 if any of the 8 banks g*4+b is open. It is rejected with reason 4 if any of them has not recovered. An accepted refresh makes activates to those banks need k >= cfg_trfc cycles, rejected otherwise with reason 4. Other banks are unaffected.
- R8: When cfg_half_rate is high, a command in an odd cycle is rejected with reason 6. Cycles are counted from 0 at the first cycle after reset release.
- R9: A read or write with cmd_bl32 high is rejected with reason 7 unless cfg_x4 is high.
- R10: Checks are applied in priority order: slot (6) first, then unsupported (7), then the bank checks in the order given above.
- R11: A rejected command changes no bank state: no open flag, no recorded row and no interval timer.
- R12: Interval timers saturate and do not wrap. A command issued hundreds of cycles after the last event to its bank is still legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_trcd | input | CNT_W | Activate-to-column minimum, cycles |
| cfg_tras | input | CNT_W | Activate-to-precharge minimum, cycles |
| cfg_trp | input | CNT_W | Precharge-to-activate minimum, cycles |
| cfg_trfc | input | CNT_W | Refresh-busy interval, cycles |
| cfg_half_rate | input | 1 | Accept commands only in even cycles |
| cfg_x4 | input | 1 | Device is x4, long bursts permitted |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_code | input | 3 | Command code |
| cmd_bg | input | BG_W | Bank group |
| cmd_bank | input | BK_W | Bank within group |
| cmd_row | input | ROW_W | Row address for activate |
| cmd_bl32 | input | 1 | Long (32-transfer) burst requested |
| cmd_legal | output | 1 | Command is legal |
| cmd_reason | output | 3 | Rejection reason, 0 when legal |
| bank_open | output | 32 | Per-bank open flag |
| open_row | output | 32*ROW_W | Per-bank recorded row |

## Verification
The overlap that matters most is a same-bank refresh in force across eight banks while other banks keep taking activates, reads and precharges. The bench opens a bank at the refresh index so that the first refresh is rejected. It then refreshes and, during the busy window, activates a neighbouring index and reads an unrelated open bank. Each verdict and all 32 bank states are compared every cycle with an integer-based model. Half-rate slot rejection is also made to coincide with a long-burst rejection, and the reported reason shows the priority.

// File: rtl/bank_track_pkg.sv
package bank_track_pkg;

    typedef enum logic [2:0] {
        CMD_ACT     = 3'd0,
        CMD_RD      = 3'd1,
        CMD_WR      = 3'd2,
        CMD_PRE     = 3'd3,
        CMD_BANKREF = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        RSN_OK      = 3'd0,
        RSN_CLOSED  = 3'd1,
        RSN_ROWCOL  = 3'd2,
        RSN_ACTIVE  = 3'd3,
        RSN_RECOVER = 3'd4,
        RSN_OPEN    = 3'd5,
        RSN_SLOT    = 3'd6,
        RSN_UNSUP   = 3'd7
    } rsn_e;

endpackage

// File: rtl/bank_cell.sv
module bank_cell #(
    parameter int ROW_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_trcd,
    input  logic [CNT_W-1:0] cfg_tras,
    input  logic [CNT_W-1:0] cfg_trp,
    input  logic [CNT_W-1:0] cfg_trfc,
    input  logic             do_act,
    input  logic             do_pre,
    input  logic             do_ref,
    input  logic [ROW_W-1:0] row_in,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             rcd_ok,
    output logic             ras_ok,
    output logic             rec_ok
);
    localparam logic [CNT_W-1:0] AGE_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] age;
        logic             refr;
    } cell_t;

    cell_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (st_q.age != AGE_MAX) begin
            st_d.age = st_q.age + 1'b1;
        end
        if (do_act) begin
            st_d.open = 1'b1;
            st_d.row  = row_in;
            st_d.age  = CNT_W'(1);
            st_d.refr = 1'b0;
        end else if (do_pre) begin
            st_d.open = 1'b0;
            st_d.age  = CNT_W'(1);
            st_d.refr = 1'b0;
        end else if (do_ref) begin
            st_d.age  = CNT_W'(1);
            st_d.refr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.open <= 1'b0;
            st_q.row  <= '0;
            st_q.age  <= AGE_MAX;
            st_q.refr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign open_o = st_q.open;
    assign row_o  = st_q.row;
    assign rcd_ok = st_q.age >= cfg_trcd;
    assign ras_ok = st_q.age >= cfg_tras;
    assign rec_ok = st_q.refr ? (st_q.age >= cfg_trfc) : (st_q.age >= cfg_trp);

endmodule

// File: rtl/cmd_judge.sv
module cmd_judge
    import bank_track_pkg::*;
#(
    parameter int BG_W = 3,
    parameter int BK_W = 2,
    localparam int NB  = 2 ** (BG_W + BK_W),
    localparam int NG  = 2 ** BG_W,
    localparam int BPG = 2 ** BK_W
) (
    input  logic            cmd_valid,
    input  logic [2:0]      cmd_code,
    input  logic [BG_W-1:0] cmd_bg,
    input  logic [BK_W-1:0] cmd_bank,
    input  logic            cmd_bl32,
    input  logic            cfg_half_rate,
    input  logic            cfg_x4,
    input  logic            odd_slot,
    input  logic [NB-1:0]   open_v,
    input  logic [NB-1:0]   rcd_v,
    input  logic [NB-1:0]   ras_v,
    input  logic [NB-1:0]   rec_v,
    output logic            legal,
    output logic [2:0]      reason
);
    logic [BG_W+BK_W-1:0] idx;
    logic                 grp_open;
    logic                 grp_unrec;
    logic                 is_col;
    rsn_e                 rsn;

    assign idx    = {cmd_bg, cmd_bank};
    assign is_col = (cmd_code == CMD_RD) || (cmd_code == CMD_WR);

    always_comb begin
        grp_open  = 1'b0;
        grp_unrec = 1'b0;
        for (int g = 0; g < NG; g++) begin
            grp_open  = grp_open  |  open_v[g*BPG + int'(cmd_bank)];
            grp_unrec = grp_unrec | ~rec_v[g*BPG + int'(cmd_bank)];
        end
    end

    always_comb begin
        rsn = RSN_OK;
        if (!cmd_valid) begin
            rsn = RSN_OK;
        end else if (cfg_half_rate && odd_slot) begin
            rsn = RSN_SLOT;
        end else if (cmd_code > CMD_BANKREF) begin
            rsn = RSN_UNSUP;
        end else if (is_col && cmd_bl32 && !cfg_x4) begin
            rsn = RSN_UNSUP;
        end else begin
            case (cmd_code)
                CMD_RD, CMD_WR: begin
                    if (!open_v[idx])     rsn = RSN_CLOSED;
                    else if (!rcd_v[idx]) rsn = RSN_ROWCOL;
                end
                CMD_PRE: begin
                    if (!open_v[idx])     rsn = RSN_CLOSED;
                    else if (!ras_v[idx]) rsn = RSN_ACTIVE;
                end
                CMD_ACT: begin
                    if (open_v[idx])      rsn = RSN_OPEN;
                    else if (!rec_v[idx]) rsn = RSN_RECOVER;
                end
                default: begin
                    if (grp_open)         rsn = RSN_OPEN;
                    else if (grp_unrec)   rsn = RSN_RECOVER;
                end
            endcase
        end
    end

    assign reason = rsn;
    assign legal  = cmd_valid && (rsn == RSN_OK);

endmodule

// File: rtl/bank_timing_tracker.sv
module bank_timing_tracker
    import bank_track_pkg::*;
#(
    parameter int BG_W  = 3,
    parameter int BK_W  = 2,
    parameter int ROW_W = 16,
    parameter int CNT_W = 8,
    localparam int IDX_W = BG_W + BK_W,
    localparam int NB    = 2 ** IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cfg_trcd,
    input  logic [CNT_W-1:0]   cfg_tras,
    input  logic [CNT_W-1:0]   cfg_trp,
    input  logic [CNT_W-1:0]   cfg_trfc,
    input  logic               cfg_half_rate,
    input  logic               cfg_x4,
    input  logic               cmd_valid,
    input  logic [2:0]         cmd_code,
    input  logic [BG_W-1:0]    cmd_bg,
    input  logic [BK_W-1:0]    cmd_bank,
    input  logic [ROW_W-1:0]   cmd_row,
    input  logic               cmd_bl32,
    output logic               cmd_legal,
    output logic [2:0]         cmd_reason,
    output logic [NB-1:0]      bank_open,
    output logic [NB*ROW_W-1:0] open_row
);
    logic              phase_q, phase_d;
    logic [NB-1:0]     rcd_v, ras_v, rec_v;
    logic [IDX_W-1:0]  idx;

    assign idx = {cmd_bg, cmd_bank};

    always_comb begin
        phase_d = ~phase_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end

    cmd_judge #(.BG_W(BG_W), .BK_W(BK_W)) i_judge (
        .cmd_valid     (cmd_valid),
        .cmd_code      (cmd_code),
        .cmd_bg        (cmd_bg),
        .cmd_bank      (cmd_bank),
        .cmd_bl32      (cmd_bl32),
        .cfg_half_rate (cfg_half_rate),
        .cfg_x4        (cfg_x4),
        .odd_slot      (phase_q),
        .open_v        (bank_open),
        .rcd_v         (rcd_v),
        .ras_v         (ras_v),
        .rec_v         (rec_v),
        .legal         (cmd_legal),
        .reason        (cmd_reason)
    );

    for (genvar i = 0; i < NB; i++) begin : g_bank
        localparam logic [IDX_W-1:0] ID = IDX_W'(i);
        logic hit, hit_idx;
        assign hit     = cmd_legal && (idx == ID);
        assign hit_idx = cmd_legal && (cmd_bank == ID[BK_W-1:0]);

        bank_cell #(.ROW_W(ROW_W), .CNT_W(CNT_W)) i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_trcd (cfg_trcd),
            .cfg_tras (cfg_tras),
            .cfg_trp  (cfg_trp),
            .cfg_trfc (cfg_trfc),
            .do_act   (hit && (cmd_code == CMD_ACT)),
            .do_pre   (hit && (cmd_code == CMD_PRE)),
            .do_ref   (hit_idx && (cmd_code == CMD_BANKREF)),
            .row_in   (cmd_row),
            .open_o   (bank_open[i]),
            .row_o    (open_row[i*ROW_W +: ROW_W]),
            .rcd_ok   (rcd_v[i]),
            .ras_ok   (ras_v[i]),
            .rec_ok   (rec_v[i])
        );
    end

endmodule

// File: rtl/bank_timing_checker.sv
module bank_timing_checker #(
    parameter int BG_W  = 3,
    parameter int BK_W  = 2,
    parameter int ROW_W = 16,
    localparam int IDX_W = BG_W + BK_W,
    localparam int NB    = 2 ** IDX_W,
    localparam int NG    = 2 ** BG_W,
    localparam int BPG   = 2 ** BK_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_half_rate,
    input logic                cmd_code_act,
    input logic                cmd_code_pre,
    input logic                cmd_code_col,
    input logic                cmd_code_ref,
    input logic [BG_W-1:0]     cmd_bg,
    input logic [BK_W-1:0]     cmd_bank,
    input logic [ROW_W-1:0]    cmd_row,
    input logic                cmd_legal,
    input logic [NB-1:0]       bank_open,
    input logic [NB*ROW_W-1:0] open_row
);
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] prev_idx_q;
    logic [ROW_W-1:0] prev_row_q;
    logic             idx_any_open;

    assign idx = {cmd_bg, cmd_bank};

    always_comb begin
        idx_any_open = 1'b0;
        for (int g = 0; g < NG; g++) begin
            idx_any_open = idx_any_open | bank_open[g*BPG + int'(cmd_bank)];
        end
    end

    always_ff @(posedge clk) begin
        prev_idx_q <= idx;
        prev_row_q <= cmd_row;
    end

    // R3: an accepted column command targets an open bank
    a_r3_col_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_legal && cmd_code_col) |-> bank_open[idx]);

    // R6: an accepted activate opens the bank with the given row
    a_r6_act_opens: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_legal && cmd_code_act) |=>
            (bank_open[prev_idx_q] && (open_row[prev_idx_q*ROW_W +: ROW_W] == prev_row_q)));

    // R5: an accepted precharge closes the bank
    a_r5_pre_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_legal && cmd_code_pre) |=> !bank_open[prev_idx_q]);

    // R7: an accepted refresh finds all targeted banks closed
    a_r7_ref_closed: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_legal && cmd_code_ref) |-> !idx_any_open);

    // R11: a cycle without an accepted command leaves bank state alone
    a_r11_reject_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_legal |=> ($stable(bank_open) && $stable(open_row)));

    // R8: in half-rate mode no two consecutive cycles accept commands
    a_r8_half_rate_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_legal && cfg_half_rate && $past(cfg_half_rate)) |-> !$past(cmd_legal));

endmodule

bind bank_timing_tracker bank_timing_checker #(
    .BG_W  (BG_W),
    .BK_W  (BK_W),
    .ROW_W (ROW_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_half_rate (cfg_half_rate),
    .cmd_code_act  (cmd_code == 3'd0),
    .cmd_code_pre  (cmd_code == 3'd3),
    .cmd_code_col  ((cmd_code == 3'd1) || (cmd_code == 3'd2)),
    .cmd_code_ref  (cmd_code == 3'd4),
    .cmd_bg        (cmd_bg),
    .cmd_bank      (cmd_bank),
    .cmd_row       (cmd_row),
    .cmd_legal     (cmd_legal),
    .bank_open     (bank_open),
    .open_row      (open_row)
);

// File: tb/test_bank_timing_tracker.sv
`timescale 1ns/1ps
module test_bank_timing_tracker;
    localparam int ROW_W = 16;
    localparam int NB    = 32;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [7:0]        cfg_trcd, cfg_tras, cfg_trp, cfg_trfc;
    logic              cfg_half_rate, cfg_x4;
    logic              cmd_valid;
    logic [2:0]        cmd_code;
    logic [2:0]        cmd_bg;
    logic [1:0]        cmd_bank;
    logic [ROW_W-1:0]  cmd_row;
    logic              cmd_bl32;
    logic              cmd_legal;
    logic [2:0]        cmd_reason;
    logic [NB-1:0]     bank_open;
    logic [NB*ROW_W-1:0] open_row;

    always #4 clk = ~clk;

    bank_timing_tracker i_bank_timing_tracker (
        .clk(clk), .rst_n(rst_n),
        .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_trp(cfg_trp), .cfg_trfc(cfg_trfc),
        .cfg_half_rate(cfg_half_rate), .cfg_x4(cfg_x4),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_bg(cmd_bg), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_bl32(cmd_bl32),
        .cmd_legal(cmd_legal), .cmd_reason(cmd_reason),
        .bank_open(bank_open), .open_row(open_row)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 0;
    int m_open[NB];
    int m_row[NB];
    int m_evt[NB];
    int m_ref[NB];

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    function automatic bit recovered(input int b);
        int age = cyc - m_evt[b];
        return m_ref[b] != 0 ? (age >= int'(cfg_trfc)) : (age >= int'(cfg_trp));
    endfunction

    function automatic int model_reason(input int code, input int bg, input int bk, input bit bl32);
        int b = bg * 4 + bk;
        int age = cyc - m_evt[b];
        if (cfg_half_rate && (cyc % 2 == 1)) return 6;
        if (code > 4) return 7;
        if ((code == 1 || code == 2) && bl32 && !cfg_x4) return 7;
        if (code == 1 || code == 2) begin
            if (m_open[b] == 0) return 1;
            if (age < int'(cfg_trcd)) return 2;
            return 0;
        end
        if (code == 3) begin
            if (m_open[b] == 0) return 1;
            if (age < int'(cfg_tras)) return 3;
            return 0;
        end
        if (code == 0) begin
            if (m_open[b] != 0) return 5;
            if (!recovered(b)) return 4;
            return 0;
        end
        for (int g = 0; g < 8; g++) if (m_open[g*4+bk] != 0) return 5;
        for (int g = 0; g < 8; g++) if (!recovered(g*4+bk)) return 4;
        return 0;
    endfunction

    task automatic compare_state(input string tag);
        for (int i = 0; i < NB; i++) begin
            check(tag, $sformatf("open[%0d]", i), int'(bank_open[i]), m_open[i]);
            check(tag, $sformatf("row[%0d]", i), int'(open_row[i*ROW_W +: ROW_W]), m_row[i]);
        end
    endtask

    task automatic issue(input bit valid, input int code, input int bg, input int bk,
                         input int row, input bit bl32, input string tag);
        int er;
        bit el;
        cmd_valid = valid;
        cmd_code  = 3'(code);
        cmd_bg    = 3'(bg);
        cmd_bank  = 2'(bk);
        cmd_row   = ROW_W'(row);
        cmd_bl32  = bl32;
        #1;
        er = valid ? model_reason(code, bg, bk, bl32) : 0;
        el = valid && (er == 0);
        check(tag, "reason", int'(cmd_reason), er);
        check(tag, "legal", int'(cmd_legal), int'(el));
        @(posedge clk);
        if (el) begin
            if (code == 0) begin
                m_open[bg*4+bk] = 1; m_row[bg*4+bk] = row;
                m_evt[bg*4+bk] = cyc; m_ref[bg*4+bk] = 0;
            end else if (code == 3) begin
                m_open[bg*4+bk] = 0; m_evt[bg*4+bk] = cyc; m_ref[bg*4+bk] = 0;
            end else if (code == 4) begin
                for (int g = 0; g < 8; g++) begin
                    m_evt[g*4+bk] = cyc; m_ref[g*4+bk] = 1;
                end
            end
        end
        cyc++;
        @(negedge clk);
        compare_state(tag);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(0, 0, 0, 0, 0, 0, "R1");
    endtask

    task automatic wait_age(input int b, input int k);
        while ((cyc - m_evt[b]) < k) idle(1);
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB; i++) begin
            m_open[i] = 0; m_row[i] = 0; m_evt[i] = -100000; m_ref[i] = 0;
        end
        rst_n = 0;
        cfg_trcd = 18; cfg_tras = 39; cfg_trp = 18; cfg_trfc = 30;
        cfg_half_rate = 0; cfg_x4 = 0;
        cmd_valid = 0; cmd_code = 0; cmd_bg = 0; cmd_bank = 0; cmd_row = 0; cmd_bl32 = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        cyc = 0;
        compare_state("R1");
        idle(2);

        // closed-bank access
        issue(1, 1, 1, 1, 0, 0, "R3");
        issue(1, 2, 1, 1, 0, 0, "R3");
        issue(1, 3, 1, 1, 0, 0, "R5");
        // activate, reactivate, rejected row change
        issue(1, 0, 1, 1, 16'h1234, 0, "R6");
        issue(1, 0, 1, 1, 16'h1234, 0, "R6");
        issue(1, 0, 1, 1, 16'h0bad, 0, "R11");
        // activate-to-column boundary
        wait_age(5, 17);
        issue(1, 1, 1, 1, 0, 0, "R4");
        issue(1, 1, 1, 1, 0, 0, "R4");
        issue(1, 2, 1, 1, 0, 0, "R4");
        // long bursts
        issue(1, 1, 1, 1, 0, 1, "R9");
        cfg_x4 = 1;
        issue(1, 2, 1, 1, 0, 1, "R9");
        cfg_x4 = 0;
        // reserved codes
        issue(1, 6, 1, 1, 0, 0, "R2");
        issue(1, 5, 0, 0, 0, 0, "R2");
        // active-to-precharge boundary
        wait_age(5, 38);
        issue(1, 3, 1, 1, 0, 0, "R5");
        issue(1, 3, 1, 1, 0, 0, "R5");
        // precharge-to-activate boundary
        wait_age(5, 17);
        issue(1, 0, 1, 1, 16'h00ff, 0, "R6");
        issue(1, 0, 1, 1, 16'h00ff, 0, "R6");
        // same-bank refresh on index 2
        issue(1, 0, 3, 2, 7, 0, "R7");
        issue(1, 4, 0, 2, 0, 0, "R7");
        wait_age(14, 39);
        issue(1, 3, 3, 2, 0, 0, "R7");
        issue(1, 4, 5, 2, 0, 0, "R7");
        wait_age(14, 18);
        issue(1, 4, 5, 2, 0, 0, "R7");
        issue(1, 0, 0, 1, 16'h4444, 0, "R7");
        issue(1, 1, 1, 1, 0, 0, "R7");
        wait_age(2, 29);
        issue(1, 0, 0, 2, 16'h5555, 0, "R7");
        issue(1, 0, 0, 2, 16'h5555, 0, "R7");
        issue(1, 0, 7, 2, 16'h6666, 0, "R7");
        // half-rate slots and priority
        cfg_half_rate = 1;
        if (cyc % 2 == 0) idle(1);
        issue(1, 1, 1, 1, 0, 0, "R8");
        issue(1, 1, 1, 1, 0, 0, "R8");
        issue(1, 3, 1, 1, 0, 1, "R10");
        issue(1, 1, 1, 1, 0, 1, "R10");
        issue(1, 3, 2, 0, 0, 0, "R11");
        issue(1, 7, 1, 1, 0, 0, "R10");
        cfg_half_rate = 0;
        issue(1, 0, 1, 1, 0, 0, "R10");
        // saturation after a long idle
        idle(300);
        issue(1, 1, 1, 1, 0, 0, "R12");
        issue(1, 3, 1, 1, 0, 0, "R12");
        issue(1, 0, 1, 1, 16'h7777, 0, "R6");
        idle(300);
        issue(1, 3, 0, 1, 0, 0, "R12");
        issue(1, 0, 0, 1, 16'h8888, 0, "R12");
        idle(2);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule